// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-bit storage and shift register. Its parallel data pins serve two purposes: they present the register contents, and they supply the data for a parallel load. A two-bit mode select chooses among four operations on each rising clock edge: keep the contents, shift toward the high end, shift toward the low end, or load the parallel word. An active-low synchronous clear takes priority over the mode select and over the data inputs.

The shared pins are modelled as three signals: a data-in bus, a data-out bus and a drive enable. A pad wrapper can combine them into a true bidirectional pin. Either of two active-high disable inputs releases the pins. The load mode releases them on its own as well, so that an external source can drive the word to be loaded.

Each end stage has its own serial input and its own always-driven serial output. This lets several registers be chained into a longer word.

Top module: `shift_store_reg`

## Requirements
- R1: While `rstN` is low at a rising clock edge, all bits become 0 at that edge, whatever `modeSel`, `pinIn` and the serial inputs carry; this includes load mode.
- R2: With `rstN` high and `modeSel` = 2'b00 (hold), the contents are unchanged by the edge.
- R3: With `modeSel` = 2'b01 (shift up), the edge moves bit i into bit i+1 and places `serInLow` into bit 0.
- R4: With `modeSel` = 2'b10 (shift down), the edge moves bit i into bit i-1 and places `serInHigh` into bit 7.
- R5: With `modeSel` = 2'b11 (load), the edge copies `pinIn` into the register.
- R6: `pinOut` always equals the current register contents, whether or not the pins are driven.
- R7: `pinDrive` is 0 whenever `offA` or `offB` is 1.
- R8: `pinDrive` is 0 when `modeSel` = 2'b11, and 1 in every other mode when `offA` and `offB` are both 0.
- R9: Clear, hold, shift and load operate identically while `pinDrive` is 0.
- R10: `serOutLow` always equals bit 0 and `serOutHigh` always equals bit 7, independent of `offA` and `offB`.
- R11: Two registers chained through their serial pins (high serial output of the first feeding the low serial input of the second, and low serial output of the second feeding the high serial input of the first) behave as one 16-bit register in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous clear |
| modeSel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| offA | input | 1 | Active-high pin drive disable |
| offB | input | 1 | Second active-high pin drive disable |
| serInLow | input | 1 | Serial data entering bit 0 in shift-up mode |
| serInHigh | input | 1 | Serial data entering bit 7 in shift-down mode |
| pinIn | input | 8 | Data sensed on the shared pins, used by load |
| pinOut | output | 8 | Register contents to be driven onto the shared pins |
| pinDrive | output | 1 | High when the shared pins are to be driven |
| serOutLow | output | 1 | Bit 0, always driven |
| serOutHigh | output | 1 | Bit 7, always driven |

## Verification
The embedded properties check every cycle that a clear zeroes the word one edge later, and that hold, both shift directions and load each produce the word their mode implies from the previous state. They also check that the load mode and either disable input always release the pins. The scenarios are needed to show that the clear beats a simultaneous load, that the full truth table of the drive enable also turns the pins on when it should, and that operations continue while the pins are released. The two-device chain through the serial pins in both directions can only be shown by the scenarios as well.

// File: rtl/shift_store_pkg.sv
package shift_store_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  // Strobes from control to datapath; all zero means keep the word.
  typedef struct packed {
    logic clear;
    logic load;
    logic shiftUp;
    logic shiftDown;
  } stepCtl_t;

endpackage

// File: rtl/shift_store_ctrl.sv
module shift_store_ctrl
  import shift_store_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic [1:0] modeSel,
  input  logic     offA,
  input  logic     offB,
  output stepCtl_t ctl,
  output logic     pinDrive
);

  mode_e mode;
  assign mode = mode_e'(modeSel);

  // Clear wins over every mode.
  always_comb begin
    ctl = '0;
    if (!rstN) begin
      ctl.clear = 1'b1;
    end else begin
      unique case (mode)
        MODE_UP:   ctl.shiftUp   = 1'b1;
        MODE_DOWN: ctl.shiftDown = 1'b1;
        MODE_LOAD: ctl.load      = 1'b1;
        default:   ctl           = '0;
      endcase
    end
  end

  // Pins released by either disable, or by load mode so the bus is free.
  logic anyOff;
  logic loadRelease;
  assign anyOff      = offA | offB;
  assign loadRelease = (mode == MODE_LOAD);
  assign pinDrive    = ~(anyOff | loadRelease);

  AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (offA || offB) |-> !pinDrive);                                   // R7
  AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |-> !pinDrive);                               // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctl) <= 1);                                           // R2

endmodule

// File: rtl/shift_store_dp.sv
module shift_store_dp
  import shift_store_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  stepCtl_t         ctl,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic lowerSrc;
    logic upperSrc;
    if (i == 0) begin : g_low_end
      assign lowerSrc = serInLow;
    end else begin : g_low_mid
      assign lowerSrc = q[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign upperSrc = serInHigh;
    end else begin : g_high_mid
      assign upperSrc = q[i+1];
    end
    assign nextQ[i] = ctl.clear     ? 1'b0 :
                      ctl.load      ? pinIn[i] :
                      ctl.shiftUp   ? lowerSrc :
                      ctl.shiftDown ? upperSrc : q[i];
  end

  always_ff @(posedge clk) begin
    q <= nextQ;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    ctl.clear |=> (q == '0));                                        // R1
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl == '0) |=> $stable(q));                                     // R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.shiftUp |=> (q == {$past(q[TOP-1:0]), $past(serInLow)}));    // R3
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.shiftDown |=> (q == {$past(serInHigh), $past(q[TOP:1])}));   // R4
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.load |=> (q == $past(pinIn)));                               // R5

endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
  import shift_store_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             offA,
  input  logic             offB,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic             pinDrive,
  output logic             serOutLow,
  output logic             serOutHigh
);

  stepCtl_t         ctl;
  logic [WIDTH-1:0] word;

  shift_store_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .offA     (offA),
    .offB     (offB),
    .ctl      (ctl),
    .pinDrive (pinDrive)
  );

  shift_store_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .ctl       (ctl),
    .serInLow  (serInLow),
    .serInHigh (serInHigh),
    .pinIn     (pinIn),
    .q         (word)
  );

  assign pinOut     = word;
  assign serOutLow  = word[0];
  assign serOutHigh = word[WIDTH-1];

endmodule

// File: tb/shift_store_reg_test.sv
module shift_store_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rstN = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         offA = 1'b0;
  logic         offB = 1'b0;
  logic         sInLow = 1'b0;
  logic         sInHigh = 1'b0;
  logic [W-1:0] dinA = '0;
  logic [W-1:0] dinB = '0;
  logic         cascadeOn = 1'b0;

  logic [W-1:0] outA, outB;
  logic         driveA, driveB, soLA, soHA, soLB, soHB;
  logic         aHighIn, bLowIn;

  assign aHighIn = cascadeOn ? soLB : sInHigh;
  assign bLowIn  = cascadeOn ? soHA : 1'b0;

  shift_store_reg #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .offA(offA), .offB(offB),
    .serInLow(sInLow), .serInHigh(aHighIn), .pinIn(dinA),
    .pinOut(outA), .pinDrive(driveA), .serOutLow(soLA), .serOutHigh(soHA)
  );

  shift_store_reg #(.WIDTH(W)) uutB (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .offA(offA), .offB(offB),
    .serInLow(bLowIn), .serInHigh(sInHigh), .pinIn(dinB),
    .pinOut(outB), .pinDrive(driveB), .serOutLow(soLB), .serOutHigh(soHB)
  );

  int total = 0;
  int bad = 0;
  logic [W-1:0] expA = '0;
  logic [W-1:0] expB = '0;

  function automatic logic [W-1:0] refNext(logic [W-1:0] q, logic r, logic [1:0] m,
                                           logic lo, logic hi, logic [W-1:0] d);
    if (!r) return '0;
    case (m)
      2'b01:   return {q[W-2:0], lo};
      2'b10:   return {hi, q[W-1:1]};
      2'b11:   return d;
      default: return q;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic r, logic [1:0] m, logic oa, logic ob,
                       logic lo, logic hi, logic [W-1:0] d);
    @(negedge clk);
    rstN = r; modeSel = m; offA = oa; offB = ob;
    sInLow = lo; sInHigh = hi; dinA = d;
  endtask

  // One rising edge; model advances, outputs compared 1 time unit later.
  task automatic step(string tag);
    logic [W-1:0] nA, nB;
    logic aHi, bLo;
    aHi = cascadeOn ? expB[0] : sInHigh;
    bLo = cascadeOn ? expA[W-1] : 1'b0;
    nA = refNext(expA, rstN, modeSel, sInLow, aHi, dinA);
    nB = refNext(expB, rstN, modeSel, bLo, sInHigh, dinB);
    @(posedge clk);
    #1;
    expA = nA;
    expB = nB;
    chk(tag, {8'h00, outA}, {8'h00, expA});
    chk("R10 serial ends", {14'h0, soHA, soLA}, {14'h0, expA[W-1], expA[0]});
    if (cascadeOn) chk(tag, {outB, outA}, {expB, expA});
  endtask

  task automatic testReset();
    drive(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
    step("R1 reset with load pending");
    chk("R1 reset state", {8'h0, outA}, 16'h0000);
    drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    step("R5 load ff");
    drive(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A);
    step("R1 reset beats load");
    drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
    step("R5 load c3");
    drive(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R1 reset beats shift");
  endtask

  task automatic testLoadHold();
    drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    #1 chk("R8 load releases pins", {15'h0, driveA}, 16'h0000);
    step("R5 load a5");
    drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C);
    for (int k = 0; k < 3; k++) step("R2 hold");
    chk("R2 hold value", {8'h0, outA}, 16'h00A5);
  endtask

  task automatic testShifts();
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 2'b01, 1'b0, 1'b0, k[0], ~k[0], 8'h00);
      step("R3 shift up");
    end
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 2'b10, 1'b0, 1'b0, k[1], k[0], 8'hFF);
      step("R4 shift down");
    end
  endtask

  task automatic testDriveTable();
    for (int c = 0; c < 16; c++) begin
      logic [1:0] m;
      logic oa, ob, want;
      m = c[1:0]; oa = c[2]; ob = c[3];
      want = !(oa || ob || (m == 2'b11));
      drive(1'b1, m, oa, ob, c[0], c[1], 8'h96 ^ c[7:0]);
      #1;
      chk(oa || ob ? "R7 disable table" : "R8 mode table",
          {15'h0, driveA}, {15'h0, want});
      chk("R6 data bus follows word", {8'h0, outA}, {8'h0, expA});
      step(want ? "R9 op while driven" : "R9 op while released");
    end
    drive(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R9 reset while released");
  endtask

  task automatic testCascade();
    cascadeOn = 1'b1;
    dinB = 8'h7E;
    drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81);
    step("R11 cascade load");
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 2'b01, 1'b0, 1'b0, k[0], 1'b0, 8'h00);
      step("R11 cascade shift up");
    end
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, k[1], 8'h00);
      step("R11 cascade shift down");
    end
    cascadeOn = 1'b0;
  endtask

  logic finished = 1'b0;

  initial begin
    testReset();
    testLoadHold();
    testShifts();
    testDriveTable();
    testCascade();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule